// File: doc/BRIEF.md
# Three-Way Instruction Decode Steering

This block is the decode-group front end of an out-of-order core. Each cycle it is offered up to three instructions whose boundaries are already marked. Each instruction carries an instruction tag and the number of micro-operations it expands to. The block steers the instructions onto three decoders. Decoder 0 handles any instruction of one to four micro-ops. Decoders 1 and 2 accept only single-micro-op instructions. Any instruction longer than four micro-ops is handed to a microcode sequencer, which emits its micro-ops in groups of up to four, one group per cycle.

The micro-ops of one cycle are collected in a staging register. From there they move into a decoded-operation queue that holds at most six micro-ops. When two micro-ops of the same instruction are produced together, they travel as one fused double-width queue entry. A consumer such as rename drains the queue one entry per cycle through a valid/ready handshake. If a cycle's micro-ops do not all fit in the queue, the remainder waits in the staging register and decode stalls until it has moved in.

The input side is a ready/take interface. `in_ready` says that decode may consume instructions this cycle. `in_take` says how many of the leading instruction slots are consumed at the coming clock edge.

Top module: `decode_steer_top`

## Requirements
- R1: In the first cycle after synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An instruction in slot 0 with a count of 1 to 4 is consumed in one cycle, and all of its micro-ops reach the output with indices 0 up to count-1.
- R3: Single-micro-op instructions in slots 1 and 2 are consumed in the same cycle as slot 0, so `in_take` can be 3. Slot 2 is taken only when slot 1 is also taken.
- R4: An instruction with a count above 1 in slot 1 or slot 2 is not consumed, and `in_take` stops in front of it. The instruction is consumed later, once it sits in slot 0.
- R5: An instruction in slot 0 with a count above 4 is consumed alone (`in_take`=1) and goes to the microcode sequencer. `in_ready` stays 0 while the sequencer emits groups of at most 4 micro-ops.
- R6: Micro-ops 2k and 2k+1 of one instruction leave as one fused entry, with `out_hi_vld`=1 and `out_hi` carrying index 2k+1. The last micro-op of an odd count, and every single-micro-op instruction, leaves with `out_hi_vld`=0.
- R7: The queue never holds more than 6 micro-ops. Micro-ops that do not fit are held rather than dropped, and `in_ready` is 0 while any are held.
- R8: Entries leave in program order. Each output field is {tag, index}: `out_lo[7:4]` is the instruction tag and `out_lo[3:0]` is the micro-op index.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output entry stays unchanged into the next cycle.
- R10: Only a contiguous run of valid slots starting at slot 0 can be consumed. If slot 0 is invalid, `in_take` is 0, and a valid slot that follows an invalid one is not taken. `in_take` is 0 whenever `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 3 | Per-slot instruction valid; bit s is slot s |
| in_cnt | input | 12 | Micro-op counts (1 to 15); slot s uses bits [4s+3:4s] |
| in_tag | input | 12 | Instruction tags; slot s uses bits [4s+3:4s] |
| in_ready | output | 1 | Decode may consume instructions this cycle |
| in_take | output | 2 | Number of leading slots consumed at the next edge |
| out_ready | input | 1 | Consumer accepts the head entry |
| out_valid | output | 1 | Head entry present |
| out_lo | output | 8 | First micro-op of the entry as {tag, index} |
| out_hi | output | 8 | Second micro-op as {tag, index}, or zero if not fused |
| out_hi_vld | output | 1 | Entry is a fused pair |

## Verification
A table of slot patterns isolates the steering rules. It covers three single-micro-op instructions, a full 4+1+1 group, a multi-micro-op instruction in slot 1 or slot 2, holes in the valid mask, and a long instruction in slot 0. Each pattern shows whether the take count stops at the correct slot and whether exactly the expected number of micro-ops emerges. A 40-instruction mixed stream is then run twice, once with the consumer always ready and once with a stalling consumer. Every entry is compared against the tag, index and pairing predicted from the instruction counts, which separates order and pairing faults from stall faults. Directed runs with the consumer blocked, and with a ten-micro-op instruction, exercise the held-excess path and the sequencer stall.

// File: rtl/ds_pkg.sv
package ds_pkg;
    localparam int TAG_W = 4;
    localparam int CNT_W = 4;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // one queue entry: a micro-op, or two consecutive micro-ops of one instruction
    typedef struct packed {
        tag_t tag;
        cnt_t idx;
        logic fused;
    } qent_t;

    function automatic int ent_uops(qent_t e);
        return e.fused ? 2 : 1;
    endfunction
endpackage

// File: rtl/ds_steer.sv
module ds_steer
    import ds_pkg::*;
#(
    parameter int SLOTS    = 3,
    parameter int DEC0_MAX = 4,
    parameter int GRP_N    = 4,
    parameter int TK_W     = $clog2(SLOTS + 1),
    parameter int GN_W     = $clog2(GRP_N + 1)
) (
    input  logic             en,
    input  logic [SLOTS-1:0] vld,
    input  cnt_t             cnt [SLOTS],
    input  tag_t             tag [SLOTS],
    output logic [TK_W-1:0]  take,
    output logic             to_seq,
    output qent_t            grp [GRP_N],
    output logic [GN_W-1:0]  grp_n
);
    always_comb begin
        int   nt;
        int   ne;
        logic stop;
        nt     = 0;
        ne     = 0;
        stop   = 1'b0;
        to_seq = 1'b0;
        for (int g = 0; g < GRP_N; g++) grp[g] = '0;
        if (en && vld[0]) begin
            nt = 1;
            if (int'(cnt[0]) > DEC0_MAX) begin
                to_seq = 1'b1;
            end else begin
                // complex decoder: pair consecutive micro-ops
                for (int k = 0; k < DEC0_MAX; k += 2) begin
                    if (k < int'(cnt[0])) begin
                        grp[ne].tag   = tag[0];
                        grp[ne].idx   = cnt_t'(k);
                        grp[ne].fused = (k + 1 < int'(cnt[0]));
                        ne++;
                    end
                end
                // simple decoders: single micro-op instructions only, in order
                for (int s = 1; s < SLOTS; s++) begin
                    if (!stop && vld[s] && cnt[s] == cnt_t'(1)) begin
                        grp[ne].tag   = tag[s];
                        grp[ne].idx   = '0;
                        grp[ne].fused = 1'b0;
                        ne++;
                        nt++;
                    end else begin
                        stop = 1'b1;
                    end
                end
            end
        end
        take  = TK_W'(nt);
        grp_n = GN_W'(ne);
    end
endmodule

// File: rtl/ds_useq.sv
module ds_useq
    import ds_pkg::*;
#(
    parameter int GROUP = 4,
    parameter int GRP_N = 4,
    parameter int GN_W  = $clog2(GRP_N + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  tag_t            ld_tag,
    input  cnt_t            ld_cnt,
    input  logic            adv,
    output logic            busy,
    output qent_t           grp [GRP_N],
    output logic [GN_W-1:0] grp_n
);
    tag_t s_tag;
    cnt_t s_base;
    cnt_t s_rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            s_tag  <= '0;
            s_base <= '0;
            s_rem  <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            s_tag  <= ld_tag;
            s_base <= '0;
            s_rem  <= ld_cnt;
        end else if (adv && busy) begin
            if (int'(s_rem) <= GROUP) begin
                busy  <= 1'b0;
                s_rem <= '0;
            end else begin
                s_rem <= s_rem - cnt_t'(GROUP);
            end
            s_base <= s_base + cnt_t'(GROUP);
        end
    end

    always_comb begin
        int n;
        int ne;
        n  = busy ? ((int'(s_rem) < GROUP) ? int'(s_rem) : GROUP) : 0;
        ne = 0;
        for (int g = 0; g < GRP_N; g++) grp[g] = '0;
        for (int k = 0; k < GROUP; k += 2) begin
            if (k < n) begin
                grp[k/2].tag   = s_tag;
                grp[k/2].idx   = s_base + cnt_t'(k);
                grp[k/2].fused = (k + 1 < n);
                ne++;
            end
        end
        grp_n = GN_W'(ne);
    end
endmodule

// File: rtl/ds_queue.sv
module ds_queue
    import ds_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int PUSH_N = 4,
    parameter int PN_W   = $clog2(PUSH_N + 1),
    parameter int UW     = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  qent_t           push_ent [PUSH_N],
    input  logic [PN_W-1:0] push_n,
    input  logic            pop,
    output qent_t           head,
    output logic            nonempty,
    output logic [UW-1:0]   uops
);
    localparam int PW = $clog2(DEPTH);

    qent_t          mem [DEPTH];
    logic [PW-1:0]  wp;
    logic [PW-1:0]  rp;
    logic [UW-1:0]  ents;
    int             push_u;

    function automatic logic [PW-1:0] wrap(int a);
        return (a >= DEPTH) ? PW'(a - DEPTH) : PW'(a);
    endfunction

    always_comb begin
        push_u = 0;
        for (int i = 0; i < PUSH_N; i++)
            if (i < int'(push_n)) push_u += ent_uops(push_ent[i]);
    end

    assign head     = mem[rp];
    assign nonempty = (ents != '0);

    always_ff @(posedge clk) begin
        for (int i = 0; i < PUSH_N; i++)
            if (i < int'(push_n)) mem[wrap(int'(wp) + i)] <= push_ent[i];
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            ents <= '0;
            uops <= '0;
        end else begin
            wp   <= wrap(int'(wp) + int'(push_n));
            if (pop) rp <= wrap(int'(rp) + 1);
            ents <= UW'(int'(ents) + int'(push_n) - (pop ? 1 : 0));
            uops <= UW'(int'(uops) + push_u - (pop ? ent_uops(head) : 0));
        end
    end
endmodule

// File: rtl/decode_steer_top.sv
module decode_steer_top
    import ds_pkg::*;
#(
    parameter int SLOTS    = 3,
    parameter int DEC0_MAX = 4,
    parameter int Q_UOPS   = 6,
    parameter int GRP_N    = DEC0_MAX / 2 + SLOTS - 1,
    parameter int TK_W     = $clog2(SLOTS + 1),
    parameter int ID_W     = TAG_W + CNT_W,
    parameter int UW       = $clog2(Q_UOPS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SLOTS-1:0]       in_vld,
    input  logic [SLOTS*CNT_W-1:0] in_cnt,
    input  logic [SLOTS*TAG_W-1:0] in_tag,
    output logic                   in_ready,
    output logic [TK_W-1:0]        in_take,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [ID_W-1:0]        out_lo,
    output logic [ID_W-1:0]        out_hi,
    output logic                   out_hi_vld
);
    localparam int GN_W = $clog2(GRP_N + 1);

    cnt_t s_cnt [SLOTS];
    tag_t s_tag [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_unpack
        assign s_cnt[s] = in_cnt[s*CNT_W +: CNT_W];
        assign s_tag[s] = in_tag[s*TAG_W +: TAG_W];
    end

    qent_t            stg [GRP_N];
    logic [GN_W-1:0]  stg_n;
    logic [GN_W-1:0]  push_n;
    logic             stg_clear;
    logic [UW-1:0]    q_uops;
    logic             q_ne;
    qent_t            q_head;
    logic             seq_busy;
    logic             dec_en;
    logic             to_seq;
    qent_t            dec_grp [GRP_N];
    logic [GN_W-1:0]  dec_n;
    qent_t            seq_grp [GRP_N];
    logic [GN_W-1:0]  seq_n;
    qent_t            src [GRP_N];
    logic [GN_W-1:0]  src_n;

    // longest in-order prefix of the staged entries that fits the free room
    always_comb begin
        int   room;
        int   acc;
        int   np;
        logic stop;
        room = Q_UOPS - int'(q_uops);
        acc  = 0;
        np   = 0;
        stop = 1'b0;
        for (int i = 0; i < GRP_N; i++) begin
            if (!stop && i < int'(stg_n) && acc + ent_uops(stg[i]) <= room) begin
                acc += ent_uops(stg[i]);
                np++;
            end else begin
                stop = 1'b1;
            end
        end
        push_n = GN_W'(np);
    end

    assign stg_clear = (push_n == stg_n);
    assign dec_en    = stg_clear && !seq_busy;
    assign in_ready  = dec_en;

    ds_steer #(.SLOTS(SLOTS), .DEC0_MAX(DEC0_MAX), .GRP_N(GRP_N)) u_steer (
        .en     (dec_en),
        .vld    (in_vld),
        .cnt    (s_cnt),
        .tag    (s_tag),
        .take   (in_take),
        .to_seq (to_seq),
        .grp    (dec_grp),
        .grp_n  (dec_n)
    );

    ds_useq #(.GROUP(DEC0_MAX), .GRP_N(GRP_N)) u_useq (
        .clk    (clk),
        .rst    (rst),
        .load   (to_seq),
        .ld_tag (s_tag[0]),
        .ld_cnt (s_cnt[0]),
        .adv    (stg_clear),
        .busy   (seq_busy),
        .grp    (seq_grp),
        .grp_n  (seq_n)
    );

    always_comb begin
        for (int g = 0; g < GRP_N; g++) src[g] = seq_busy ? seq_grp[g] : dec_grp[g];
        src_n = seq_busy ? seq_n : dec_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_n <= '0;
            for (int i = 0; i < GRP_N; i++) stg[i] <= '0;
        end else if (stg_clear) begin
            stg_n <= src_n;
            for (int i = 0; i < GRP_N; i++) stg[i] <= src[i];
        end else begin
            stg_n <= stg_n - push_n;
            for (int i = 0; i < GRP_N; i++)
                stg[i] <= (i + int'(push_n) < GRP_N) ? stg[i + int'(push_n)] : '0;
        end
    end

    ds_queue #(.DEPTH(Q_UOPS), .PUSH_N(GRP_N)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push_ent (stg),
        .push_n   (push_n),
        .pop      (q_ne && out_ready),
        .head     (q_head),
        .nonempty (q_ne),
        .uops     (q_uops)
    );

    assign out_valid  = q_ne;
    assign out_lo     = {q_head.tag, q_head.idx};
    assign out_hi     = q_head.fused ? {q_head.tag, q_head.idx + cnt_t'(1)} : '0;
    assign out_hi_vld = q_head.fused;
endmodule

// File: rtl/ds_chk.sv
module ds_chk #(
    parameter int SLOTS  = 3,
    parameter int Q_UOPS = 6,
    parameter int ID_W   = 8,
    parameter int TK_W   = 2,
    parameter int UW     = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [SLOTS-1:0] in_vld,
    input logic             in_ready,
    input logic [TK_W-1:0]  in_take,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ID_W-1:0]  out_lo,
    input logic             out_hi_vld,
    input logic             seq_busy,
    input logic [UW-1:0]    q_uops
);
    int lead;
    always_comb begin
        logic stop;
        lead = 0;
        stop = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!stop && in_vld[s]) lead++;
            else stop = 1'b1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> (!out_valid && in_ready));

    // R7
    queue_cap_chk: assert property (@(posedge clk) disable iff (rst)
        int'(q_uops) <= Q_UOPS);

    // R5
    seq_stall_chk: assert property (@(posedge clk) disable iff (rst)
        seq_busy |-> !in_ready);

    // R10
    take_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        int'(in_take) <= lead);

    // R10
    take_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> (in_take == '0));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_lo) && $stable(out_hi_vld)));
endmodule

bind decode_steer_top ds_chk #(
    .SLOTS(SLOTS), .Q_UOPS(Q_UOPS), .ID_W(ID_W), .TK_W(TK_W), .UW(UW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_vld     (in_vld),
    .in_ready   (in_ready),
    .in_take    (in_take),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_lo     (out_lo),
    .out_hi_vld (out_hi_vld),
    .seq_busy   (seq_busy),
    .q_uops     (q_uops)
);

// File: tb/sim_decode_steer_top.sv
module sim_decode_steer_top;
    localparam int CLK_P = 10;
    localparam int NROW  = 10;

    typedef struct packed {
        logic [2:0] m;
        logic [3:0] c0;
        logic [3:0] c1;
        logic [3:0] c2;
        logic [1:0] tk;
        logic [3:0] up;
    } row_t;

    // valid mask (bit s = slot s), counts, expected take, expected micro-ops out
    localparam row_t ROWS [NROW] = '{
        '{3'b111, 4'd1, 4'd1, 4'd1, 2'd3, 4'd3},  // R3
        '{3'b111, 4'd4, 4'd1, 4'd1, 2'd3, 4'd6},  // R2 R3
        '{3'b111, 4'd2, 4'd2, 4'd1, 2'd1, 4'd2},  // R4
        '{3'b111, 4'd1, 4'd3, 4'd1, 2'd1, 4'd1},  // R4
        '{3'b111, 4'd3, 4'd1, 4'd2, 2'd2, 4'd4},  // R4
        '{3'b101, 4'd1, 4'd1, 4'd1, 2'd1, 4'd1},  // R10
        '{3'b110, 4'd1, 4'd1, 4'd1, 2'd0, 4'd0},  // R10
        '{3'b111, 4'd7, 4'd1, 4'd1, 2'd1, 4'd7},  // R5
        '{3'b001, 4'd4, 4'd1, 4'd1, 2'd1, 4'd4},  // R2
        '{3'b111, 4'd1, 4'd1, 4'd4, 2'd2, 4'd2}   // R4
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  in_vld = '0;
    logic [11:0] in_cnt = '0;
    logic [11:0] in_tag = '0;
    logic        in_ready;
    logic [1:0]  in_take;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [7:0]  out_lo;
    logic [7:0]  out_hi;
    logic        out_hi_vld;

    always #(CLK_P/2) clk = ~clk;

    decode_steer_top u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_cnt(in_cnt), .in_tag(in_tag),
        .in_ready(in_ready), .in_take(in_take), .out_ready(out_ready),
        .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi), .out_hi_vld(out_hi_vld)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    int   cnts [64];
    int   n_inst;
    int   ptr;
    bit   feed_on;
    bit   sb_on;
    int   sb_inst;
    int   sb_k;
    int   popped;
    int   last_take;
    bit   last_ready;
    bit   hold_prev;
    logic [7:0] prev_lo;
    logic [2:0] drv_v;
    int   drv_c [3];
    int   drv_t [3];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        finish_run();
    end

    task automatic step(input bit ordy);
        @(negedge clk);
        out_ready = ordy;
        if (feed_on) begin
            for (int s = 0; s < 3; s++) begin
                drv_v[s] = (ptr + s < n_inst);
                drv_c[s] = (ptr + s < n_inst) ? cnts[ptr + s] : 0;
                drv_t[s] = (ptr + s) % 16;
            end
        end
        in_vld = drv_v;
        for (int s = 0; s < 3; s++) begin
            in_cnt[s*4 +: 4] = 4'(drv_c[s]);
            in_tag[s*4 +: 4] = 4'(drv_t[s]);
        end
        #1;
        if (hold_prev) // R9
            chk(out_valid && out_lo == prev_lo, "R9 held entry", int'(out_lo), int'(prev_lo));
        hold_prev = out_valid && !out_ready;
        prev_lo   = out_lo;
        if (out_valid && out_ready) begin
            popped += out_hi_vld ? 2 : 1;
            if (sb_on) begin
                if (sb_inst >= n_inst) begin
                    chk(1'b0, "R8 extra entry", int'(out_lo), -1);
                end else begin
                    int  c;
                    bit  f;
                    c = cnts[sb_inst];
                    f = (sb_k + 1 < c);
                    chk(out_lo == {4'(sb_inst % 16), 4'(sb_k)}, "R8 order",
                        int'(out_lo), int'({4'(sb_inst % 16), 4'(sb_k)}));
                    chk(out_hi_vld == f && (!f || out_hi == {4'(sb_inst % 16), 4'(sb_k + 1)}),
                        "R6 pairing", int'(out_hi_vld), int'(f));
                    sb_k += 2;
                    if (sb_k >= c) begin
                        sb_k = 0;
                        sb_inst++;
                    end
                end
            end
        end
        last_ready = in_ready;
        last_take  = int'(in_take);
        @(posedge clk);
        if (feed_on) ptr += int'(in_take);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drv_v = '0;
        in_vld = '0;
        feed_on = 1'b0;
        hold_prev = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic start_stream();
        ptr = 0;
        sb_inst = 0;
        sb_k = 0;
        sb_on = 1'b1;
        feed_on = 1'b1;
    endtask

    task automatic drain(input int mode);
        for (int c = 0; c < 3000 && !(ptr == n_inst && sb_inst == n_inst); c++)
            step(mode == 0 ? 1'b1 : (c % 3 != 2));
        chk(ptr == n_inst && sb_inst == n_inst, "R8 stream complete", sb_inst, n_inst);
    endtask

    initial begin
        feed_on = 1'b0;
        sb_on = 1'b0;
        popped = 0;
        drv_v = '0;
        for (int s = 0; s < 3; s++) begin
            drv_c[s] = 0;
            drv_t[s] = s;
        end
        do_reset();

        // R1 reset state
        #1;
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(in_take == 2'd0, "R1 in_take", int'(in_take), 0);

        // steering table
        for (int r = 0; r < NROW; r++) begin
            popped = 0;
            drv_v = ROWS[r].m;
            drv_c[0] = int'(ROWS[r].c0);
            drv_c[1] = int'(ROWS[r].c1);
            drv_c[2] = int'(ROWS[r].c2);
            step(1'b1);
            chk(last_ready && last_take == int'(ROWS[r].tk), "R3/R4 take count (R10 R5)",
                last_take, int'(ROWS[r].tk));
            drv_v = '0;
            for (int i = 0; i < 12; i++) step(1'b1);
            chk(popped == int'(ROWS[r].up), "R2 micro-op total", popped, int'(ROWS[r].up));
        end

        // mixed stream, consumer always ready, then stalling consumer
        n_inst = 40;
        for (int i = 0; i < 40; i++) begin
            int c;
            c = (i * 7 + 3) % 11;
            cnts[i] = (c < 4) ? 1 : c - 3;
        end
        do_reset();
        start_stream();
        drain(0);
        do_reset();
        start_stream();
        drain(1);

        // R7 overflow: consumer blocked
        n_inst = 8;
        cnts[0] = 4; cnts[1] = 1; cnts[2] = 1; cnts[3] = 4;
        cnts[4] = 1; cnts[5] = 1; cnts[6] = 2; cnts[7] = 1;
        do_reset();
        start_stream();
        for (int i = 0; i < 6; i++) step(1'b0);
        chk(ptr == 6, "R7 groups accepted while blocked", ptr, 6);
        chk(last_ready == 1'b0, "R7 in_ready held low", int'(last_ready), 0);
        chk(out_valid == 1'b1, "R7 queue holds entries", int'(out_valid), 1);
        drain(0);

        // R5 sequencer stall
        n_inst = 2;
        cnts[0] = 10;
        cnts[1] = 1;
        do_reset();
        start_stream();
        step(1'b1);
        chk(last_take == 1, "R5 long instruction taken alone", last_take, 1);
        begin
            int stall;
            stall = 0;
            step(1'b1);
            while (!last_ready && stall < 50) begin
                stall++;
                step(1'b1);
            end
            chk(stall >= 3 && stall <= 8, "R5 stall cycles", stall, 3);
        end
        drain(0);

        finish_run();
    end
endmodule